// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a target device on a two-wire serial bus (one clock line, one open-drain data line). It gives a bus master access to a bank of 16-bit registers that live elsewhere on the chip, through an 8-bit register pointer. Both bus lines are oversampled by the system clock. The block finds start and stop conditions. It answers only to its own 7-bit device address, and it pulls the data line low only for its acknowledge bits and for the zero bits of read data.

On the chip side the block has a plain register-file port. It provides a register address, a 16-bit write word and a one-cycle write strobe. It takes back a 16-bit read word that must follow the address in the same cycle. A word is carried on the bus as two bytes. The pointer moves on by one each time a whole word has been written or read, so a master can stream through neighbouring registers in a single transfer.

Top module: `twi_reg_slave`

## Requirements
- R1: A falling data line while the clock line is high (start) begins a new address byte from any state, including in the middle of a transfer (repeated start). A rising data line while the clock is high (stop) returns the block to idle and releases the data line.
- R2: The block acknowledges an address byte whose upper seven bits equal 7'b1011100, by holding the data line low for the ninth clock. Bit 0 of that byte gives the direction: 0xB8 writes and 0xB9 reads.
- R3: The block does not acknowledge an address byte with any other upper seven bits. Until the next start it then drives nothing and issues no write strobe.
- R4: In a write, the block loads the first byte after the address into the 8-bit register pointer and acknowledges it.
- R5: The block acknowledges every data byte of a write. The bytes pair into 16-bit words, the first byte giving bits 15:8. When the second byte of a pair completes, the block raises reg_we for one cycle with reg_addr holding the pointer. The pointer then steps by one and wraps from 0xFF to 0x00.
- R6: When a stop or start ends a write after only the first byte of a word, that byte is dropped and no strobe is issued.
- R7: After a start with 0xB9, the block sends the word at the current pointer, upper byte first and MSB first. The pointer is kept from earlier transfers and steps by one after both bytes of a word. Words keep coming while the master acknowledges.
- R8: When the master does not acknowledge a read byte, the read ends: the block releases the data line and stays off the bus until the next start.
- R9: The block pulls the data line low only in its acknowledge slots and for zero bits of read data. It changes its drive only after a falling clock edge (or a start or stop), so the line follows the master during the master's own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 leaves it released |
| reg_addr | output | AW (8) | Register pointer presented to the register bank |
| reg_wdata | output | DW (16) | Word to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | DW (16) | Word held at reg_addr, valid in the same cycle |

## Verification
When the second byte of a word completes, two things happen in the same system-clock cycle. The engine raises the write strobe for the register bank, and it starts pulling the data line low for its acknowledge. In a read, the falling edge that ends a word's last bit both releases the data line and advances the pointer that selects the next word. Every multi-word transfer provokes these coincidences, and the wrap write at pointer 0xFF provokes them at the edge of the address space. They are judged by sampling the acknowledge bit on the bus, by counting strobes in the bench's register model, and by comparing each word read back with the value the bench computed.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WR,
    ST_RD,
    ST_SKIP
  } twi_state_e;

  // device byte carries 7 address bits above the direction bit
  function automatic logic addr_match(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  function automatic logic dir_is_read(input logic [7:0] b);
    return b[0];
  endfunction

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, hold;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        hold <= RST_VAL[i];
      end else begin
        meta <= d_i[i];
        hold <= meta;
      end
    end
    assign q_o[i] = hold;
  end
endmodule

// File: rtl/twi_cond.sv
module twi_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign ev_rise  = scl_s & ~scl_q;
  assign ev_fall  = ~scl_s & scl_q;
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5C,
  parameter int         AW       = 8,
  parameter int         DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic [DW-1:0] rdata,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output twi_state_e    state
);
  localparam int BPW = DW / 8;
  localparam int BW  = (BPW > 1) ? $clog2(BPW) : 1;
  localparam logic [BW-1:0] LAST_B = BW'(BPW - 1);

  logic [2:0]    cnt;
  logic          got8, in_ack, nack, rw;
  logic [7:0]    shreg;
  logic [DW-9:0] acc;
  logic [DW-1:0] acc_next;
  logic [DW-1:0] tx;
  logic [BW-1:0] bidx;

  assign acc_next = {acc, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      got8   <= 1'b0;
      in_ack <= 1'b0;
      nack   <= 1'b0;
      rw     <= 1'b0;
      shreg  <= '0;
      acc    <= '0;
      tx     <= '0;
      bidx   <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      we     <= 1'b0;
      wdata  <= '0;
    end else begin
      we <= 1'b0;
      if (we) ptr <= ptr + AW'(1);
      if (ev_start || ev_stop) begin
        state  <= ev_start ? ST_DEV : ST_IDLE;
        cnt    <= '0;
        got8   <= 1'b0;
        in_ack <= 1'b0;
        nack   <= 1'b0;
        bidx   <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_REG, ST_WR: begin
            if (!in_ack) begin
              if (ev_rise) begin
                shreg <= {shreg[6:0], sda_s};
                cnt   <= cnt + 3'd1;
                got8  <= (cnt == 3'd7);
              end else if (ev_fall && got8) begin
                got8 <= 1'b0;
                if (state == ST_DEV) begin
                  if (addr_match(shreg, DEV_ADDR)) begin
                    sda_oe <= 1'b1;
                    in_ack <= 1'b1;
                    rw     <= dir_is_read(shreg);
                  end else begin
                    state <= ST_SKIP;
                  end
                end else if (state == ST_REG) begin
                  sda_oe <= 1'b1;
                  in_ack <= 1'b1;
                  ptr    <= AW'(shreg);
                end else begin
                  sda_oe <= 1'b1;
                  in_ack <= 1'b1;
                  if (bidx == LAST_B) begin
                    we    <= 1'b1;
                    wdata <= acc_next;
                    bidx  <= '0;
                  end else begin
                    acc  <= acc_next[DW-9:0];
                    bidx <= bidx + BW'(1);
                  end
                end
              end
            end else if (ev_fall) begin
              in_ack <= 1'b0;
              sda_oe <= 1'b0;
              if (state == ST_DEV) begin
                if (rw) begin
                  state  <= ST_RD;
                  tx     <= rdata;
                  sda_oe <= ~rdata[DW-1];
                  cnt    <= '0;
                end else begin
                  state <= ST_REG;
                end
              end else if (state == ST_REG) begin
                state <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (!in_ack) begin
              if (ev_fall) begin
                if (cnt == 3'd7) begin
                  sda_oe <= 1'b0;
                  in_ack <= 1'b1;
                  nack   <= 1'b0;
                  cnt    <= '0;
                  if (bidx == LAST_B) begin
                    bidx <= '0;
                    ptr  <= ptr + AW'(1);
                  end else begin
                    bidx <= bidx + BW'(1);
                  end
                end else begin
                  tx     <= tx << 1;
                  sda_oe <= ~tx[DW-2];
                  cnt    <= cnt + 3'd1;
                end
              end
            end else begin
              if (ev_rise) begin
                nack <= sda_s;
              end else if (ev_fall) begin
                in_ack <= 1'b0;
                if (nack) begin
                  state <= ST_SKIP;
                end else if (bidx == '0) begin
                  tx     <= rdata;
                  sda_oe <= ~rdata[DW-1];
                end else begin
                  tx     <= tx << 1;
                  sda_oe <= ~tx[DW-2];
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5C,
  parameter int         AW       = 8,
  parameter int         DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  logic [1:0] pads_s;
  logic       scl_s, sda_s;
  logic       ev_rise, ev_fall, ev_start, ev_stop;
  twi_state_e state;

  twi_sync #(.W(2), .RST_VAL(2'b11)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (pads_s)
  );
  assign scl_s = pads_s[1];
  assign sda_s = pads_s[0];

  twi_cond i_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  twi_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) i_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .rdata    (reg_rdata),
    .sda_oe   (sda_oe),
    .ptr      (reg_addr),
    .wdata    (reg_wdata),
    .we       (reg_we),
    .state    (state)
  );
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk
  import twi_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          ev_fall,
  input twi_state_e    state
);
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_pointer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == $past(reg_addr) + AW'(1));

  assert_drive_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(ev_fall));

  assert_release_on_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> ($past(ev_fall) || $past(ev_start) || $past(ev_stop)));

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);

  assert_skip_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !reg_we);
endmodule

bind twi_reg_slave twi_reg_slave_chk #(.AW(AW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .ev_start (ev_start),
  .ev_stop  (ev_stop),
  .ev_fall  (ev_fall),
  .state    (state)
);

// File: tb/test_twi_reg_slave.sv
module test_twi_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  wire        sda_oe;
  wire [7:0]  reg_addr;
  wire [15:0] reg_wdata;
  wire        reg_we;
  wire [15:0] reg_rdata;
  wire        sda_line = sda_m & ~sda_oe;

  logic [15:0] mem     [0:255];
  logic [15:0] exp_mem [0:255];
  int total = 0, bad = 0, we_cnt = 0;
  bit done = 1'b0;

  assign reg_rdata = mem[reg_addr];
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;
  always @(posedge clk) if (rst_n && reg_we) we_cnt <= we_cnt + 1;

  twi_reg_slave i_twi_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] start_word(input int i);
    return 16'(i * 257) ^ 16'h5A3C;
  endfunction

  function automatic logic [7:0] wrap_idx(input logic [7:0] a, input int k);
    return 8'(int'(a) + k);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b1; wait_q(); wait_q();
  endtask

  // R9: during master bits the line must equal what the master sends
  task automatic send_bit(input bit b);
    sda_m = b; wait_q(); scl_m = 1'b1; wait_q();
    check(sda_line == b, "R9 line follows master bit", sda_line, b);
    wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic recv_bit(output bit v);
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q(); v = sda_line; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    bit v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(v);
    ack = ~v;
  endtask

  task automatic read_byte(output logic [7:0] b, input bit nack);
    bit v;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(v);
      b[i] = v;
    end
    send_bit(nack);
  endtask

  task automatic read_words(input logic [7:0] a, input int n);
    logic [7:0] hb, lb;
    for (int k = 0; k < n; k++) begin
      read_byte(hb, 1'b0);
      read_byte(lb, k == n - 1);
      check({hb, lb} == exp_mem[wrap_idx(a, k)], "R7 read word", {hb, lb}, exp_mem[wrap_idx(a, k)]);
    end
    wait_q();
    check(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
    read_byte(hb, 1'b1);
    check(hb == 8'hFF, "R8 silent after nack", hb, 8'hFF);
    bus_stop();
  endtask

  task automatic do_write(input logic [7:0] a, input int n);
    int w0;
    bit ack;
    logic [15:0] w;
    w0 = we_cnt;
    bus_start();
    write_byte(8'hB8, ack); check(ack, "R2 write address ack", ack, 1);
    write_byte(a, ack);     check(ack, "R4 pointer byte ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      w = 16'($urandom);
      write_byte(w[15:8], ack); check(ack, "R5 upper byte ack", ack, 1);
      write_byte(w[7:0], ack);  check(ack, "R5 lower byte ack", ack, 1);
      exp_mem[wrap_idx(a, k)] = w;
    end
    bus_stop();
    check(we_cnt - w0 == n, "R5 strobe count", we_cnt - w0, n);
    for (int k = 0; k < n; k++)
      check(mem[wrap_idx(a, k)] == exp_mem[wrap_idx(a, k)], "R5 stored word",
            mem[wrap_idx(a, k)], exp_mem[wrap_idx(a, k)]);
  endtask

  task automatic do_read(input logic [7:0] a, input int n);
    bit ack;
    bus_start();
    write_byte(8'hB8, ack); check(ack, "R2 write address ack", ack, 1);
    write_byte(a, ack);     check(ack, "R4 pointer byte ack", ack, 1);
    bus_start();
    write_byte(8'hB9, ack); check(ack, "R2 read address ack", ack, 1);
    read_words(a, n);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0;
    bit ack;
    logic [7:0] b;
    void'($urandom(32'h1D5E_0C41));
    for (int i = 0; i < 256; i++) begin
      mem[i] = start_word(i);
      exp_mem[i] = start_word(i);
    end
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R9 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0 && reg_we == 1'b0, "R5 idle after reset", {sda_oe, reg_we}, 0);

    // directed: plain write then read back
    do_write(8'h10, 2);
    do_read(8'h10, 2);

    // R5 pointer wraps from FF to 00
    do_write(8'hFF, 2);
    do_read(8'hFF, 2);

    // R3 foreign device address, write direction
    w0 = we_cnt;
    bus_start();
    write_byte(8'hBA, ack); check(!ack, "R3 foreign address not acked", ack, 0);
    write_byte(8'h20, ack); check(!ack, "R3 ignored byte not acked", ack, 0);
    write_byte(8'h00, ack); check(!ack, "R3 ignored byte not acked", ack, 0);
    write_byte(8'h00, ack); check(!ack, "R3 ignored byte not acked", ack, 0);
    bus_stop();
    check(we_cnt == w0, "R3 no write strobe", we_cnt - w0, 0);
    // R3 foreign device address, read direction
    bus_start();
    write_byte(8'hBB, ack); check(!ack, "R3 foreign read address not acked", ack, 0);
    read_byte(b, 1'b1);     check(b == 8'hFF, "R3 no read drive", b, 8'hFF);
    bus_stop();

    // R6 dangling byte before stop
    w0 = we_cnt;
    bus_start();
    write_byte(8'hB8, ack); write_byte(8'h30, ack);
    write_byte(8'hBE, ack); write_byte(8'hEF, ack);
    write_byte(8'h77, ack); check(ack, "R5 dangling byte still acked", ack, 1);
    bus_stop();
    exp_mem[8'h30] = 16'hBEEF;
    check(we_cnt - w0 == 1, "R6 one strobe for one word", we_cnt - w0, 1);
    check(mem[8'h30] == 16'hBEEF, "R6 full word stored", mem[8'h30], 16'hBEEF);
    check(mem[8'h31] == exp_mem[8'h31], "R6 partial word dropped", mem[8'h31], exp_mem[8'h31]);

    // R1 repeated start in the middle of a word
    w0 = we_cnt;
    bus_start();
    write_byte(8'hB8, ack); write_byte(8'h40, ack); write_byte(8'h12, ack);
    bus_start();
    write_byte(8'hB9, ack); check(ack, "R1 repeated start address ack", ack, 1);
    read_words(8'h40, 1);
    check(we_cnt == w0, "R6 partial word dropped on restart", we_cnt - w0, 0);

    // R7 read straight away continues from the kept pointer
    bus_start();
    write_byte(8'hB9, ack); check(ack, "R7 direct read ack", ack, 1);
    read_words(8'h41, 1);

    // constrained random transfers
    for (int it = 0; it < 10; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom_range(0, 255));
      n = int'($urandom_range(1, 3));
      do_write(a, n);
      do_read(a, n);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule